// File: doc/BRIEF.md
# Receive Mailbox Allocator

This block sits between a CAN bit engine and a bank of message mailboxes. Each frame that the bit engine finishes is stored into exactly one mailbox. The block picks that mailbox with a fixed search from index 0 upward. It writes the identifier, length, remote flag and payload into the mailbox and marks the mailbox full. A full mailbox is locked: it holds its contents until software re-arms it by writing a bit mask. A mailbox configured for overwrite still accepts a frame when nothing else is free. When that happens it records that a frame was lost.

Frames arrive on a valid/ready stream. The block never applies back-pressure. `frm_ready` is low only while reset is asserted and stays high after that. A frame transfers in every cycle where `frm_valid` and `frm_ready` are both high. If no mailbox can take a transferred frame, that frame is discarded. Mailbox modes, the re-arm mask and the read-out port are plain control and status pins. The `mb_full` vector feeds the interrupt logic as the per-mailbox bits of the global status word.

Top module: `rxmb_alloc`

## Requirements
- R1: An accepted frame is stored into the lowest-indexed mailbox that is in receive mode (code 1) or overwrite mode (code 2) and is not full.
- R2: A full mailbox keeps its stored identifier, status and data unchanged and takes no further frame until it is re-armed. The one exception is the case in R4.
- R3: In a cycle with `rearm_we` high, every mailbox whose bit in `rearm_mask` is 1 becomes empty and its lost flag clears. Several mailboxes can clear in one write. Mailboxes whose mask bit is 0 keep their state.
- R4: If no mailbox is free, the frame overwrites the lowest-indexed full overwrite-mode mailbox. That mailbox stays full and its lost flag, read as status bit 24, becomes 1.
- R5: `rd_status` for the selected mailbox is built as follows: DLC in bits 19:16, remote flag in bit 20, full flag in bit 23, lost flag in bit 24. All other bits are 0.
- R6: `rd_id` is built as follows. For an extended frame, bit 29 is 1 and the 29-bit identifier is in bits 28:0. For a standard frame, identifier bits 10:0 appear at bits 28:18 and every other bit is 0. `rd_data` returns the stored 64-bit payload.
- R7: A frame that finds neither a free mailbox nor an overwrite-mode mailbox is dropped, and no mailbox state changes.
- R8: Mailboxes in disabled mode (code 0), transmit mode (code 3) or any code of 4 or above are never chosen. Mailbox i takes its mode from `mode_cfg[3*i+2:3*i]`.
- R9: `mb_full[i]` is 1 from the clock edge that stores a frame into mailbox i until the edge that re-arms it.
- R10: During reset and after it, every mailbox is empty with its lost flag clear, and its read-out is all zero.
- R11: `frm_ready` is 0 while reset is asserted. It becomes 1 at the first clock edge after reset is released and then stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | A received frame is offered |
| frm_ready | output | 1 | Block can take a frame (high whenever out of reset) |
| frm_ext | input | 1 | Frame uses a 29-bit identifier |
| frm_rtr | input | 1 | Remote frame flag |
| frm_id | input | 29 | Identifier; standard frames use bits 10:0 |
| frm_dlc | input | 4 | Data length code |
| frm_data | input | 64 | Payload bytes |
| mode_cfg | input | 48 | 3-bit mode per mailbox, mailbox i at bits 3*i+2:3*i |
| rearm_we | input | 1 | Apply the re-arm mask this cycle |
| rearm_mask | input | 16 | One bit per mailbox to empty |
| rd_sel | input | 4 | Mailbox shown on the read-out port |
| rd_id | output | 32 | Identifier word of the selected mailbox |
| rd_status | output | 32 | Status word of the selected mailbox |
| rd_data | output | 64 | Payload of the selected mailbox |
| mb_full | output | 16 | Full flag of every mailbox |

## Verification
The bench fills the mailboxes in order when the modes are mixed, so a search that does not skip disabled, transmit or unknown-mode mailboxes puts a frame into the wrong slot. It pushes a frame into an already full overwrite mailbox to show the lost flag being set. It also checks that a free overwrite mailbox does not raise that flag, and that a design preferring a full overwrite slot over a free one would instead leave a higher free slot empty. A re-arm and a frame arrive in the same cycle to prove the search uses the state before the re-arm. A partial mask is used to catch a design that clears unselected bits. With every eligible slot full and no overwrite slot present, the bench checks that the dropped frame leaves the stored identifiers and flags untouched.

// File: rtl/rxmb_pkg.sv
package rxmb_pkg;

  localparam int MB_ID_W   = 29;
  localparam int MB_DLC_W  = 4;
  localparam int MB_DATA_W = 64;
  localparam int MB_MODE_W = 3;
  localparam int MB_REG_W  = 32;

  localparam int ST_DLC_LSB = 16;
  localparam int ST_RTR_BIT = 20;
  localparam int ST_RDY_BIT = 23;
  localparam int ST_LOST_BIT = 24;
  localparam int ID_EXT_BIT = 29;
  localparam int ID_STD_LSB = 18;
  localparam int ID_STD_W   = 11;

  localparam logic [MB_MODE_W-1:0] MODE_OFF = 3'd0;
  localparam logic [MB_MODE_W-1:0] MODE_RX  = 3'd1;
  localparam logic [MB_MODE_W-1:0] MODE_OVW = 3'd2;
  localparam logic [MB_MODE_W-1:0] MODE_TX  = 3'd3;

  typedef struct packed {
    logic                 ext;
    logic                 rtr;
    logic [MB_ID_W-1:0]   id;
    logic [MB_DLC_W-1:0]  dlc;
    logic [MB_DATA_W-1:0] data;
  } rx_frame_t;

endpackage

// File: rtl/rxmb_pick.sv
module rxmb_pick #(
  parameter int N = 16
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         found
);

  // isolate the lowest set request bit
  assign gnt   = req & (~req + {{(N-1){1'b0}}, 1'b1});
  assign found = |req;

endmodule

// File: rtl/rxmb_idfmt.sv
module rxmb_idfmt
  import rxmb_pkg::*;
(
  input  logic                ext,
  input  logic [MB_ID_W-1:0]  id,
  output logic [MB_REG_W-1:0] word
);

  always_comb begin
    word = '0;
    if (ext) begin
      word[ID_EXT_BIT]  = 1'b1;
      word[MB_ID_W-1:0] = id;
    end else begin
      word[ID_STD_LSB +: ID_STD_W] = id[ID_STD_W-1:0];
    end
  end

endmodule

// File: rtl/rxmb_slot.sv
module rxmb_slot
  import rxmb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr,
  input  logic      clr,
  input  rx_frame_t frm,
  output logic      full_q,
  output logic      lost_q,
  output rx_frame_t frm_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      lost_q <= 1'b0;
      frm_q  <= '0;
    end else if (wr) begin
      // a store wins over a re-arm aimed at the same slot
      frm_q  <= frm;
      full_q <= 1'b1;
      lost_q <= lost_q | full_q;
    end else if (clr) begin
      full_q <= 1'b0;
      lost_q <= 1'b0;
    end
  end

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !wr) |=> (!full_q && !lost_q)); // R3

  AST_WR_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> full_q); // R9

endmodule

// File: rtl/rxmb_alloc.sv
module rxmb_alloc
  import rxmb_pkg::*;
#(
  parameter int NUM_MB = 16,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        frm_valid,
  output logic                        frm_ready,
  input  logic                        frm_ext,
  input  logic                        frm_rtr,
  input  logic [MB_ID_W-1:0]          frm_id,
  input  logic [MB_DLC_W-1:0]         frm_dlc,
  input  logic [MB_DATA_W-1:0]        frm_data,
  input  logic [NUM_MB*MB_MODE_W-1:0] mode_cfg,
  input  logic                        rearm_we,
  input  logic [NUM_MB-1:0]           rearm_mask,
  input  logic [IDX_W-1:0]            rd_sel,
  output logic [MB_REG_W-1:0]         rd_id,
  output logic [MB_REG_W-1:0]         rd_status,
  output logic [MB_DATA_W-1:0]        rd_data,
  output logic [NUM_MB-1:0]           mb_full
);

  logic              rdy_q;
  logic              accept;
  rx_frame_t         in_frm;
  logic [NUM_MB-1:0] is_rx, is_ovw;
  logic [NUM_MB-1:0] free_req, ovw_req;
  logic [NUM_MB-1:0] gnt_free, gnt_ovw;
  logic              found_free, found_ovw;
  logic [NUM_MB-1:0] wr_vec, clr_vec;
  logic [NUM_MB-1:0] lost_vec;
  rx_frame_t         slot_frm [NUM_MB];
  rx_frame_t         sel_frm;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  assign frm_ready = rdy_q;
  assign accept    = frm_valid && rdy_q;

  assign in_frm.ext  = frm_ext;
  assign in_frm.rtr  = frm_rtr;
  assign in_frm.id   = frm_id;
  assign in_frm.dlc  = frm_dlc;
  assign in_frm.data = frm_data;

  for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
    logic [MB_MODE_W-1:0] mode_i;
    assign mode_i      = mode_cfg[i*MB_MODE_W +: MB_MODE_W];
    assign is_rx[i]    = (mode_i == MODE_RX);
    assign is_ovw[i]   = (mode_i == MODE_OVW);
    assign free_req[i] = (is_rx[i] || is_ovw[i]) && !mb_full[i];
    assign ovw_req[i]  = is_ovw[i] && mb_full[i];

    rxmb_slot i_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (wr_vec[i]),
      .clr    (clr_vec[i]),
      .frm    (in_frm),
      .full_q (mb_full[i]),
      .lost_q (lost_vec[i]),
      .frm_q  (slot_frm[i])
    );

    AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (mb_full[i] && !is_ovw[i]) |=> $stable(slot_frm[i])); // R2

    AST_LOST_NEEDS_OVW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lost_vec[i]) |-> ($past(mb_full[i]) && $past(is_ovw[i]))); // R4

    AST_SKIP_OTHER_MODES: assert property (@(posedge clk) disable iff (!rst_n)
      wr_vec[i] |-> (is_rx[i] || is_ovw[i])); // R8
  end

  rxmb_pick #(.N(NUM_MB)) i_pick_free (
    .req   (free_req),
    .gnt   (gnt_free),
    .found (found_free)
  );

  rxmb_pick #(.N(NUM_MB)) i_pick_ovw (
    .req   (ovw_req),
    .gnt   (gnt_ovw),
    .found (found_ovw)
  );

  always_comb begin
    wr_vec = '0;
    if (accept) begin
      if (found_free)     wr_vec = gnt_free;
      else if (found_ovw) wr_vec = gnt_ovw;
    end
  end

  assign clr_vec = rearm_we ? rearm_mask : '0;

  // read-out port
  assign sel_frm = slot_frm[rd_sel];
  assign rd_data = sel_frm.data;

  rxmb_idfmt i_idfmt (
    .ext  (sel_frm.ext),
    .id   (sel_frm.id),
    .word (rd_id)
  );

  always_comb begin
    rd_status = '0;
    rd_status[ST_DLC_LSB +: MB_DLC_W] = sel_frm.dlc;
    rd_status[ST_RTR_BIT]  = sel_frm.rtr;
    rd_status[ST_RDY_BIT]  = mb_full[rd_sel];
    rd_status[ST_LOST_BIT] = lost_vec[rd_sel];
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec)); // R1

  AST_FULL_ONLY_IF_NONE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && |(wr_vec & mb_full)) |-> !found_free); // R4

  AST_DROP_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !found_free && !found_ovw && !rearm_we) |=> ($stable(mb_full) && $stable(lost_vec))); // R7

  AST_READY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    frm_ready |=> frm_ready); // R11

endmodule

// File: tb/test_rxmb_alloc.sv
module test_rxmb_alloc;
  import rxmb_pkg::*;

  localparam int NMB = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_valid = 1'b0;
  logic        frm_ready;
  logic        frm_ext = 1'b0;
  logic        frm_rtr = 1'b0;
  logic [28:0] frm_id = '0;
  logic [3:0]  frm_dlc = '0;
  logic [63:0] frm_data = '0;
  logic [47:0] mode_cfg = '0;
  logic        rearm_we = 1'b0;
  logic [15:0] rearm_mask = '0;
  logic [3:0]  rd_sel = '0;
  logic [31:0] rd_id, rd_status;
  logic [63:0] rd_data;
  logic [15:0] mb_full;

  int checks = 0;
  int errs = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rxmb_alloc i_rxmb_alloc (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_ext(frm_ext), .frm_rtr(frm_rtr), .frm_id(frm_id), .frm_dlc(frm_dlc),
    .frm_data(frm_data), .mode_cfg(mode_cfg), .rearm_we(rearm_we),
    .rearm_mask(rearm_mask), .rd_sel(rd_sel), .rd_id(rd_id),
    .rd_status(rd_status), .rd_data(rd_data), .mb_full(mb_full)
  );

  typedef struct packed {
    logic        fv;
    logic        rw;
    logic [15:0] mask;
    logic [15:0] exp_full;
    logic        exp_lost7;
  } vec_t;

  // modes: 0-3 rx, 4 off, 5 tx, 6 rx, 7 overwrite, 8-15 code 7
  localparam vec_t VEC [14] = '{
    '{1'b1, 1'b0, 16'h0000, 16'h0001, 1'b0},
    '{1'b1, 1'b0, 16'h0000, 16'h0003, 1'b0},
    '{1'b1, 1'b0, 16'h0000, 16'h0007, 1'b0},
    '{1'b1, 1'b0, 16'h0000, 16'h000F, 1'b0},
    '{1'b1, 1'b0, 16'h0000, 16'h004F, 1'b0},
    '{1'b1, 1'b0, 16'h0000, 16'h00CF, 1'b0},
    '{1'b1, 1'b0, 16'h0000, 16'h00CF, 1'b1},
    '{1'b0, 1'b1, 16'h0005, 16'h00CA, 1'b1},
    '{1'b1, 1'b0, 16'h0000, 16'h00CB, 1'b1},
    '{1'b1, 1'b1, 16'h0082, 16'h004D, 1'b0},
    '{1'b1, 1'b0, 16'h0000, 16'h004F, 1'b0},
    '{1'b1, 1'b0, 16'h0000, 16'h00CF, 1'b0},
    '{1'b1, 1'b0, 16'h0000, 16'h00CF, 1'b1},
    '{1'b0, 1'b1, 16'hFFFF, 16'h0000, 1'b0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_mode(input int mb, input logic [2:0] m);
    mode_cfg[mb*3 +: 3] = m;
  endtask

  task automatic send(input logic ext, input logic rtr, input logic [28:0] id,
                      input logic [3:0] dlc, input logic [63:0] data);
    @(negedge clk);
    frm_valid = 1'b1; frm_ext = ext; frm_rtr = rtr;
    frm_id = id; frm_dlc = dlc; frm_data = data;
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic rearm(input logic [15:0] m);
    @(negedge clk);
    rearm_we = 1'b1; rearm_mask = m;
    @(negedge clk);
    rearm_we = 1'b0; rearm_mask = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NMB; i++) set_mode(i, MODE_RX);
    repeat (3) @(negedge clk);
    // R10 / R11: reset state
    chk("R11 ready low in reset", {63'd0, frm_ready}, 64'd0);
    chk("R10 full empty in reset", {48'd0, mb_full}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 ready after reset", {63'd0, frm_ready}, 64'd1);
    chk("R10 status zero", {32'd0, rd_status}, 64'd0);
    chk("R10 id zero", {32'd0, rd_id}, 64'd0);

    // R5 / R6: standard remote frame into mailbox 0
    send(1'b0, 1'b1, 29'h5A3, 4'd5, 64'h0123_4567_89AB_CDEF);
    rd_sel = 4'd0; #1;
    chk("R6 std id word", {32'd0, rd_id}, {32'd0, 3'b000, 11'h5A3, 18'd0});
    chk("R5 status std", {32'd0, rd_status}, {32'd0, 32'h0090_0000 | (32'd5 << 16)});
    chk("R6 data", rd_data, 64'h0123_4567_89AB_CDEF);
    chk("R9 full after first", {48'd0, mb_full}, 64'h1);

    // extended frame into mailbox 1
    send(1'b1, 1'b0, 29'h1ABC_DEF1, 4'd8, 64'hFEED_F00D_0000_1111);
    rd_sel = 4'd1; #1;
    chk("R6 ext id word", {32'd0, rd_id}, {32'd0, 32'h2000_0000 | 32'h1ABC_DEF1});
    chk("R5 status ext", {32'd0, rd_status}, {32'd0, 32'h0088_0000});
    chk("R1 second to mb1", {48'd0, mb_full}, 64'h3);

    // R2: locked mailbox 0 keeps its contents
    send(1'b0, 1'b0, 29'h7FF, 4'd1, 64'h0);
    rd_sel = 4'd0; #1;
    chk("R2 mb0 id kept", {32'd0, rd_id}, {32'd0, 3'b000, 11'h5A3, 18'd0});
    chk("R2 mb0 data kept", rd_data, 64'h0123_4567_89AB_CDEF);
    chk("R1 third to mb2", {48'd0, mb_full}, 64'h7);

    rearm(16'hFFFF);
    chk("R3 rearm all", {48'd0, mb_full}, 64'h0);

    // table: mixed modes (R1 R3 R4 R8 R9)
    for (int i = 0; i < NMB; i++) set_mode(i, 3'd7);
    set_mode(0, MODE_RX); set_mode(1, MODE_RX); set_mode(2, MODE_RX);
    set_mode(3, MODE_RX); set_mode(4, MODE_OFF); set_mode(5, MODE_TX);
    set_mode(6, MODE_RX); set_mode(7, MODE_OVW);
    rd_sel = 4'd7;
    for (int v = 0; v < 14; v++) begin
      @(negedge clk);
      frm_valid = VEC[v].fv; frm_ext = 1'b1; frm_rtr = 1'b0;
      frm_id = 29'(v); frm_dlc = 4'(v); frm_data = 64'(v);
      rearm_we = VEC[v].rw; rearm_mask = VEC[v].mask;
      @(negedge clk);
      frm_valid = 1'b0; rearm_we = 1'b0; rearm_mask = '0;
      chk($sformatf("R1 R3 R4 R9 vec %0d full", v), {48'd0, mb_full}, {48'd0, VEC[v].exp_full});
      chk($sformatf("R4 vec %0d lost bit 24", v), {63'd0, rd_status[24]}, {63'd0, VEC[v].exp_lost7});
    end

    // R8: only mailbox 15 receives
    for (int i = 0; i < NMB; i++) set_mode(i, MODE_TX);
    set_mode(3, MODE_OFF); set_mode(9, 3'd5);
    set_mode(15, MODE_RX);
    send(1'b0, 1'b0, 29'h123, 4'd2, 64'hAA);
    rd_sel = 4'd15; #1;
    chk("R8 lands in mb15", {48'd0, mb_full}, 64'h8000);
    chk("R8 mb15 id", {32'd0, rd_id}, {32'd0, 3'b000, 11'h123, 18'd0});

    // R7: nothing free, no overwrite slot
    send(1'b1, 1'b1, 29'h0F0F_0F0F, 4'd7, 64'hBB);
    #1;
    chk("R7 full unchanged", {48'd0, mb_full}, 64'h8000);
    chk("R7 mb15 id unchanged", {32'd0, rd_id}, {32'd0, 3'b000, 11'h123, 18'd0});
    chk("R7 mb15 status unchanged", {32'd0, rd_status}, {32'd0, 32'h0082_0000});
    chk("R11 ready held", {63'd0, frm_ready}, 64'd1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule